// File: doc/BRIEF.md
# Bus Initiator Retry Limiter

This block sits next to a bus initiator and watches how every outgoing transaction terminates: normal completion, a retry request from the target, a target abort or an initiator abort. For the transaction in flight it counts the retries it has seen and compares that count with a programmable limit. Once the permitted number of retries has been used up, the next retry is converted into an abort. A limit of zero turns the check off, so a transaction may be retried forever.

Three sticky status flags record retry-limit errors, target aborts and initiator aborts. Each flag has its own interrupt enable, and the single interrupt output is the OR of the enabled flags. When a read is cut off by the retry limit, the block also pulses a transfer-error line toward the requesting host in the same cycle. A write cut off the same way raises only the status flag and the interrupt. Software reaches the limit, the enables and the flags through a small two-word register port.

Top module: `retry_limiter`

## Requirements
- R1: After reset the retry limit reads as 0xFF, all three enables read 0, all flags read 0, and `irq`, `abort_xact` and `host_err` are low.
- R2: `xact_start` clears the retry count, so retries from earlier transactions never count toward the limit of a later one.
- R3: With a limit of 0, any number of retries is accepted: `abort_xact` never rises and the retry-error flag is never set by retries.
- R4: With a limit N in 1..255, the first N retries of a transaction are accepted. Any retry seen while the count is already at or above N raises `abort_xact` combinationally, in the same cycle as that retry termination.
- R5: A limit abort sets the retry-error flag (status bit 0), and the flag is visible from the cycle after the abort.
- R6: `host_err` pulses in the abort cycle when the aborted transaction is a read (`xact_is_read` was 1 at its start). It stays low for a write.
- R7: A target-abort termination (code 2) sets status bit 1. An initiator-abort termination (code 3) sets status bit 2. A completion (code 0) sets no flag. A retry has code 1.
- R8: A flag is set whether or not its interrupt is enabled. `irq` equals the OR over the three flags, each ANDed with its enable, and it follows flag changes one cycle after the causing event.
- R9: Flags are sticky. Writing 1 to a status bit clears that flag, and `irq` drops in the following cycle. Writing 0 leaves the flag unchanged. If a set and a clear hit the same flag in the same cycle, the set wins.
- R10: Control word (address 0): bits 7:0 hold the limit, bit 16 enables the retry-error interrupt, bit 17 the target-abort interrupt and bit 18 the initiator-abort interrupt. Status word (address 1): bits 2:0. All other bits read 0 and ignore writes.
- R11: Each enable gates only its own flag: a set flag whose enable is 0 never drives `irq`, even when other enables are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xact_start | input | 1 | Start of a new transaction (one-cycle pulse) |
| xact_is_read | input | 1 | Transaction direction, sampled with `xact_start` (1 = read) |
| term_valid | input | 1 | A termination is reported this cycle |
| term_code | input | 2 | 0 complete, 1 retry, 2 target abort, 3 initiator abort |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| abort_xact | output | 1 | Turn the current retry into an abort |
| host_err | output | 1 | Transfer-error pulse to the host on an aborted read |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 8-bit count and a reset limit of 0xFF. With these values it can run the longest finite window: 255 accepted retries followed by the abort on the 256th, and a 300-retry run at limit 0 that wraps the count without ever aborting. The random phase keeps limits between 0 and 4, so aborts, read and write variants, lowered limits and flag clears all happen often within a short run.

// File: rtl/rlim_pkg.sv
package rlim_pkg;

  typedef enum logic [1:0] {
    TERM_DONE   = 2'd0,
    TERM_RETRY  = 2'd1,
    TERM_TABORT = 2'd2,
    TERM_IABORT = 2'd3
  } term_e;

  localparam int FLAG_RETRY  = 0;
  localparam int FLAG_TABORT = 1;
  localparam int FLAG_IABORT = 2;
  localparam int NUM_FLAGS   = 3;
  localparam int ENABLE_LSB  = 16;
  localparam int MAX_CNT_W   = 16;

  // A retry exceeds the window when a nonzero limit has already been reached.
  function automatic logic limit_reached(input logic [MAX_CNT_W-1:0] cnt,
                                         input logic [MAX_CNT_W-1:0] lim);
    return (lim != '0) && (cnt >= lim);
  endfunction

  // Set has priority over a write-one clear.
  function automatic logic [NUM_FLAGS-1:0] flag_next(input logic [NUM_FLAGS-1:0] cur,
                                                     input logic [NUM_FLAGS-1:0] set,
                                                     input logic [NUM_FLAGS-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/rlim_counter.sv
module rlim_counter
  import rlim_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             retry_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             over_o,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_eff;
  logic [CNT_W-1:0] cnt_d;

  assign cnt_eff = start_i ? '0 : cnt_q;
  assign over_o  = retry_i &&
                   limit_reached(MAX_CNT_W'(cnt_eff), MAX_CNT_W'(limit_i));

  always_comb begin
    cnt_d = cnt_eff;
    if (retry_i && !over_o) cnt_d = cnt_eff + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  assert_unlimited_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_i && limit_i == '0) |-> !over_o);

  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !retry_i) |=> (count_o == '0));

  assert_abort_needs_retry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    over_o |-> retry_i);

endmodule

// File: rtl/rlim_flags.sv
module rlim_flags
  import rlim_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic [NUM_FLAGS-1:0] clr_i,
  output logic [NUM_FLAGS-1:0] flags_o
);

  logic [NUM_FLAGS-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flag_next(flags_q, set_i, clr_i);
  end

  assign flags_o = flags_q;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_chk
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[g] && !clr_i[g]) |=> flags_q[g]);
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flags_q[g]);
  end

endmodule

// File: rtl/rlim_regs.sv
module rlim_regs
  import rlim_pkg::*;
#(
  parameter int          CNT_W       = 8,
  parameter logic [CNT_W-1:0] RST_LIMIT = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_i,
  input  logic                 addr_i,
  input  logic [31:0]          wdata_i,
  input  logic [NUM_FLAGS-1:0] flags_i,
  output logic [CNT_W-1:0]     limit_o,
  output logic [NUM_FLAGS-1:0] enable_o,
  output logic [NUM_FLAGS-1:0] clr_o,
  output logic [31:0]          rdata_o
);

  localparam logic [31:0] CTRL_MASK =
    32'((1 << CNT_W) - 1) | (32'((1 << NUM_FLAGS) - 1) << ENABLE_LSB);

  logic [CNT_W-1:0]     limit_q;
  logic [NUM_FLAGS-1:0] enable_q;
  logic [31:0]          ctrl_word;
  logic [31:0]          stat_word;
  logic                 unused_wbits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit_q  <= RST_LIMIT;
      enable_q <= '0;
    end else if (we_i && !addr_i) begin
      limit_q  <= wdata_i[CNT_W-1:0];
      enable_q <= wdata_i[ENABLE_LSB +: NUM_FLAGS];
    end
  end

  assign clr_o        = (we_i && addr_i) ? wdata_i[NUM_FLAGS-1:0] : '0;
  assign unused_wbits = ^(wdata_i & ~CTRL_MASK);

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CNT_W-1:0] = limit_q;
    ctrl_word[ENABLE_LSB +: NUM_FLAGS] = enable_q;
    stat_word = '0;
    stat_word[NUM_FLAGS-1:0] = flags_i;
  end

  assign rdata_o  = addr_i ? stat_word : ctrl_word;
  assign limit_o  = limit_q;
  assign enable_o = enable_q;

  assert_reserved_ctrl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_i |-> ((rdata_o & ~CTRL_MASK) == '0));

  assert_reserved_stat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_i |-> (rdata_o[31:NUM_FLAGS] == '0));

endmodule

// File: rtl/retry_limiter.sv
module retry_limiter
  import rlim_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xact_start,
  input  logic        xact_is_read,
  input  logic        term_valid,
  input  logic [1:0]  term_code,
  input  logic        reg_we,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        abort_xact,
  output logic        host_err,
  output logic        irq
);

  // Named internal events, visible to the assertions.
  logic                 retry_evt;
  logic                 tabort_evt;
  logic                 iabort_evt;
  logic                 limit_abort;
  logic                 rd_q;
  logic                 rd_eff;
  logic [CNT_W-1:0]     limit;
  logic [CNT_W-1:0]     retry_count;
  logic [NUM_FLAGS-1:0] enables;
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flag_clr;

  assign retry_evt  = term_valid && (term_code == TERM_RETRY);
  assign tabort_evt = term_valid && (term_code == TERM_TABORT);
  assign iabort_evt = term_valid && (term_code == TERM_IABORT);

  always_ff @(posedge clk) begin
    if (!rst_n)          rd_q <= 1'b0;
    else if (xact_start) rd_q <= xact_is_read;
  end
  assign rd_eff = xact_start ? xact_is_read : rd_q;

  rlim_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (xact_start),
    .retry_i (retry_evt),
    .limit_i (limit),
    .over_o  (limit_abort),
    .count_o (retry_count)
  );

  always_comb begin
    flag_set              = '0;
    flag_set[FLAG_RETRY]  = limit_abort;
    flag_set[FLAG_TABORT] = tabort_evt;
    flag_set[FLAG_IABORT] = iabort_evt;
  end

  rlim_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (flag_set),
    .clr_i   (flag_clr),
    .flags_o (flags)
  );

  rlim_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (reg_we),
    .addr_i   (reg_addr),
    .wdata_i  (reg_wdata),
    .flags_i  (flags),
    .limit_o  (limit),
    .enable_o (enables),
    .clr_o    (flag_clr),
    .rdata_o  (reg_rdata)
  );

  assign abort_xact = limit_abort;
  assign host_err   = limit_abort && rd_eff;
  assign irq        = |(flags & enables);

  assert_flag_after_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_xact |=> flags[FLAG_RETRY]);

  assert_host_err_on_retry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_err |-> (term_valid && term_code == TERM_RETRY));

  assert_write_no_host_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xact_start && !xact_is_read) |-> !host_err);

  assert_tabort_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tabort_evt |=> flags[FLAG_TABORT]);

  assert_iabort_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    iabort_evt |=> flags[FLAG_IABORT]);

  assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (enables == '0) |-> !irq);

endmodule

// File: tb/retry_limiter_tb.sv
`timescale 1ns/1ps
module retry_limiter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xact_start = 1'b0;
  logic        xact_is_read = 1'b0;
  logic        term_valid = 1'b0;
  logic [1:0]  term_code = 2'd0;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b1;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        abort_xact, host_err, irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Bench model
  logic [7:0] m_lim = 8'hFF;
  logic [7:0] m_cnt = 8'd0;
  logic [2:0] m_en = 3'b000;
  logic [2:0] m_flags = 3'b000;
  logic       m_rd = 1'b0;

  always #2 clk = ~clk;

  retry_limiter dut_i (
    .clk(clk), .rst_n(rst_n), .xact_start(xact_start), .xact_is_read(xact_is_read),
    .term_valid(term_valid), .term_code(term_code), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .abort_xact(abort_xact),
    .host_err(host_err), .irq(irq)
  );

  function automatic logic exp_abort(input logic [1:0] code, input logic [7:0] lim,
                                     input logic [7:0] cnt);
    if (code != 2'd1) return 1'b0;
    if (lim == 8'd0)  return 1'b0;
    return cnt >= lim;
  endfunction

  function automatic logic [31:0] exp_ctrl(input logic [7:0] lim, input logic [2:0] en);
    return {13'd0, en, 8'd0, lim};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic start_xact(input logic rd);
    @(negedge clk);
    xact_start = 1'b1; xact_is_read = rd;
    @(posedge clk);
    #1 xact_start = 1'b0;
    m_cnt = 8'd0; m_rd = rd;
  endtask

  task automatic term(input logic [1:0] code, input string tag);
    logic ab;
    @(negedge clk);
    term_valid = 1'b1; term_code = code;
    #1;
    ab = exp_abort(code, m_lim, m_cnt);
    chk({tag, " abort"}, 32'(abort_xact), 32'(ab));
    chk({tag, " R6 host_err"}, 32'(host_err), 32'(ab && m_rd));
    @(posedge clk);
    #1 term_valid = 1'b0;
    if (code == 2'd1 && !ab) m_cnt = m_cnt + 8'd1;
    if (ab) m_flags[0] = 1'b1;
    if (code == 2'd2) m_flags[1] = 1'b1;
    if (code == 2'd3) m_flags[2] = 1'b1;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_we = 1'b0; reg_addr = 1'b1;
    if (!a) begin m_lim = d[7:0]; m_en = d[18:16]; end
    else    m_flags = m_flags & ~d[2:0];
  endtask

  task automatic check_state(input string tag);
    @(negedge clk);
    reg_addr = 1'b0; #1;
    chk({tag, " R10 ctrl"}, reg_rdata, exp_ctrl(m_lim, m_en));
    reg_addr = 1'b1; #1;
    chk({tag, " R5 R7 status"}, reg_rdata, {29'd0, m_flags});
    chk({tag, " R8 R11 irq"}, 32'(irq), 32'(|(m_flags & m_en)));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd2024);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    reg_addr = 1'b0; #1;
    chk("R1 ctrl reset", reg_rdata, 32'h0000_00FF);
    reg_addr = 1'b1; #1;
    chk("R1 status reset", reg_rdata, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 abort", 32'(abort_xact), 32'h0);
    chk("R1 host_err", 32'(host_err), 32'h0);

    // R4: full window at reset limit 255, write transaction
    start_xact(1'b0);
    for (int i = 0; i < 256; i++) term(2'd1, "R4 limit255");
    check_state("R4 after 256");

    // R9 write zero no effect, write one clears, irq drops
    wr(1'b0, 32'h0001_0003);
    check_state("R9 enabled");
    wr(1'b1, 32'h0);
    check_state("R9 write zero");
    wr(1'b1, 32'h1);
    check_state("R9 cleared");

    // R3 unlimited
    wr(1'b0, 32'h0000_0000);
    start_xact(1'b1);
    for (int i = 0; i < 300; i++) term(2'd1, "R3 unlimited");
    check_state("R3 no flag");

    // R2 restart per transaction, R6 read abort
    wr(1'b0, 32'h0000_0003);
    start_xact(1'b1);
    for (int i = 0; i < 3; i++) term(2'd1, "R2 first");
    start_xact(1'b1);
    for (int i = 0; i < 4; i++) term(2'd1, "R2 second R6 read");
    check_state("R2 end");

    // R7 / R8 / R11: masked flags, single enable
    wr(1'b1, 32'h7);
    wr(1'b0, 32'h0002_0002);
    term(2'd3, "R7 iabort");
    check_state("R11 iabort masked");
    term(2'd2, "R7 tabort");
    check_state("R8 tabort enabled");
    term(2'd0, "R7 done");
    check_state("R7 done no flag");

    // R10 reserved bits
    wr(1'b0, 32'hFFFF_FFFF);
    check_state("R10 all ones");
    wr(1'b1, 32'hFFFF_FFF8);
    check_state("R10 status reserved");

    // Random phase
    for (int i = 0; i < 1500; i++) begin
      int unsigned r;
      r = $urandom_range(0, 19);
      if (r < 3)       start_xact(1'($urandom_range(0, 1)));
      else if (r < 13) term(2'd1, "R4 random retry");
      else if (r < 15) term(2'($urandom_range(0, 3)), "R7 random term");
      else if (r < 16) wr(1'b0, {13'd0, 3'($urandom_range(0, 7)), 8'd0,
                                 8'($urandom_range(0, 4))});
      else if (r < 17) wr(1'b1, 32'($urandom_range(0, 7)));
      else             check_state("R8 random");
    end
    check_state("R9 final");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule